// File: doc/BRIEF.md
# Burst Pseudo-SRAM Address and WAIT Sequencer

This block is the device-side control path of a synchronous burst pseudo-SRAM port. A 16-bit bus configuration word, written through the address pins under a register-write strobe, selects the burst length, wrap behaviour, initial latency code, fixed or variable latency, WAIT polarity and WAIT lead timing. When the controller latches a start address with CE# and ADV# low, the sequencer counts the initial latency, asserts a data-beat strobe with the internal word address for each beat, and drives WAIT while the data is not yet ready.

The storage array uses the word address and the beat strobe to move one word per clock. A variable-latency device doubles its first-access latency when an internal busy condition (a refresh collision) is present as the address is latched. The WAIT pin carries an output enable that is off whenever the chip is deselected.

Top module: `psram_burst_seq`

## Requirements
- R1: After reset the configuration is 16'h9D1F: continuous linear burst, latency code 3, variable latency, WAIT active high, WAIT asserted one cycle ahead; `beat_o` is low.
- R2: Length field cfg[2:0] = 001/010/011/100 gives bursts of exactly 4/8/16/32 beats, after which `beat_o` stays low until a new start.
- R3: With cfg[3] = 0 and a fixed length N, the beat address keeps its upper bits and steps its low log2(N) bits modulo N, starting from the latched address.
- R4: With cfg[3] = 1, or with a continuous burst, the beat address increments by one per beat across any boundary.
- R5: With cfg[14] = 1 the first beat appears exactly L clock edges after the latching edge, L = latency code cfg[13:11], regardless of `busy_i`.
- R6: With cfg[14] = 0 the first beat appears L edges after the latching edge, or 2L edges if `busy_i` is high at the latching edge.
- R7: Reserved codes are stored but act as defaults: latency codes 0, 1, 7 act as 3; length codes other than 001–100 act as continuous.
- R8: cfg[10] = 1 drives `wait_o` high while waiting and low otherwise; cfg[10] = 0 inverts both levels.
- R9: With cfg[8] = 0 WAIT is active in every cycle before the first beat; with cfg[8] = 1 it is released one cycle before the first beat.
- R10: `wait_oe_o` equals the inverse of `ce_n`; an edge with `ce_n` high ends any burst, so `beat_o` is low after it.
- R11: An edge with `cfg_wr` high and `ce_n` low loads `addr_i[15:0]` into the configuration and starts no burst even with `adv_n` low.
- R12: `beat_we_o` is high during beats of a burst latched with `we_n` low and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Address valid, active low |
| we_n | input | 1 | Write enable, active low, sampled with the address |
| cfg_wr | input | 1 | Configuration write strobe |
| busy_i | input | 1 | Internal busy, doubles variable latency |
| addr_i | input | AW (20) | Start address, or configuration word on bits [15:0] |
| word_addr_o | output | AW (20) | Internal word address of the current beat |
| beat_o | output | 1 | One data word transfers this cycle |
| beat_we_o | output | 1 | Current beat belongs to a write burst |
| wait_o | output | 1 | WAIT level, configured polarity |
| wait_oe_o | output | 1 | WAIT output enable |

## Verification
A wrong latency count shows at the ports as the first `beat_o` moving by one or more cycles, and the WAIT release moving with it, within the first burst after the configuration. A wrong wrap mask or beat counter shows as a mis-ordered address on the first beat crossing a length boundary, or as a burst that stops early or runs on, at most 32 beats after the start. A wrong decode of a reserved code surfaces as defaulted latency or length differing from the expected one on the very next burst.

// File: rtl/psb_pkg.sv
package psb_pkg;

  typedef struct packed {
    logic [2:0] blen_log;  // log2 of burst length (2..5)
    logic       cont;      // continuous burst
    logic       wrap;      // wrap within the length boundary
    logic [2:0] lat;       // effective latency code (2..6)
    logic       fixed;     // fixed initial latency
    logic       act_high;  // WAIT asserted high
    logic       lead;      // WAIT released one cycle ahead
  } cfg_t;

  localparam logic [15:0] CFG_RESET = 16'h9D1F;

  function automatic cfg_t decode_cfg(input logic [15:0] r);
    cfg_t c;
    c.cont = 1'b0;
    unique case (r[2:0])
      3'b001:  c.blen_log = 3'd2;
      3'b010:  c.blen_log = 3'd3;
      3'b011:  c.blen_log = 3'd4;
      3'b100:  c.blen_log = 3'd5;
      default: begin c.blen_log = 3'd5; c.cont = 1'b1; end
    endcase
    c.wrap     = ~r[3];
    c.lat      = (r[13:11] >= 3'd2 && r[13:11] <= 3'd6) ? r[13:11] : 3'd3;
    c.fixed    = r[14];
    c.act_high = r[10];
    c.lead     = r[8];
    return c;
  endfunction

endpackage

// File: rtl/psb_cfg.sv
module psb_cfg
  import psb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [15:0] wdata,
  output cfg_t        cfg
);

  logic [15:0] reg_q, reg_d;

  always_comb begin
    reg_d = reg_q;
    if (load) reg_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_q <= CFG_RESET;
    else        reg_q <= reg_d;
  end

  assign cfg = decode_cfg(reg_q);

  // R7: decoded latency never leaves the legal range
  p_lat_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.lat >= 3'd2) && (cfg.lat <= 3'd6));

endmodule

// File: rtl/psb_ctrl.sv
module psb_ctrl
  import psb_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic start,
  input  logic busy_i,
  input  logic we_i,
  input  logic last,
  input  cfg_t cfg,
  output logic beat,
  output logic beat_we,
  output logic step,
  output logic wait_act
);

  logic          active_q, active_d;
  logic          beat_q, beat_d;
  logic          we_q, we_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] lat_eff;

  always_comb begin
    lat_eff = CW'(cfg.lat);
    if (!cfg.fixed && busy_i) lat_eff = CW'(cfg.lat) << 1;
  end

  always_comb begin
    active_d = active_q;
    beat_d   = beat_q;
    we_d     = we_q;
    cnt_d    = cnt_q;
    if (!sel) begin
      active_d = 1'b0;
      beat_d   = 1'b0;
      cnt_d    = '0;
    end else if (start) begin
      active_d = 1'b1;
      beat_d   = 1'b0;
      we_d     = we_i;
      cnt_d    = lat_eff - CW'(1);
    end else if (active_q) begin
      if (beat_q) begin
        if (last) begin
          active_d = 1'b0;
          beat_d   = 1'b0;
        end
      end else if (cnt_q == '0) begin
        beat_d = 1'b1;
      end else begin
        cnt_d = cnt_q - CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      beat_q   <= 1'b0;
      we_q     <= 1'b0;
      cnt_q    <= '0;
    end else begin
      active_q <= active_d;
      beat_q   <= beat_d;
      we_q     <= we_d;
      cnt_q    <= cnt_d;
    end
  end

  assign beat     = beat_q;
  assign beat_we  = beat_q & we_q;
  assign step     = sel & ~start & active_q & beat_q & ~last;
  assign wait_act = active_q & ~beat_q & (cfg.lead ? (cnt_q != '0) : 1'b1);

  // checker: cycles since the latching edge versus the latency chosen there
  logic [CW:0] chk_q, exp_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_q <= '0;
      exp_q <= '0;
    end else if (sel && start) begin
      chk_q <= '0;
      exp_q <= {1'b0, lat_eff};
    end else if (active_q && !beat_q) begin
      chk_q <= chk_q + 1'b1;
    end
  end

  // R5 / R6: first beat lands on the latency fixed at latch time
  p_first_beat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(beat_q) |-> (chk_q == exp_q));

  // R10: an edge with the chip deselected leaves no beat
  p_beat_needs_ce_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sel) |-> !beat_q);

endmodule

// File: rtl/psb_addr.sv
module psb_addr
  import psb_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic          beat,
  input  logic [AW-1:0] start_addr,
  input  cfg_t          cfg,
  output logic [AW-1:0] addr,
  output logic          last
);

  localparam int BW = 5;

  logic [AW-1:0] addr_q, addr_d, mask, inc;
  logic [BW-1:0] bcnt_q, bcnt_d;
  logic          wrap_on;

  assign mask    = (AW'(1) << cfg.blen_log) - AW'(1);
  assign wrap_on = cfg.wrap & ~cfg.cont;
  assign inc     = addr_q + AW'(1);

  always_comb begin
    addr_d = addr_q;
    bcnt_d = bcnt_q;
    if (load) begin
      addr_d = start_addr;
      bcnt_d = '0;
    end else if (step) begin
      addr_d = wrap_on ? ((addr_q & ~mask) | (inc & mask)) : inc;
      bcnt_d = bcnt_q + BW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      bcnt_q <= '0;
    end else begin
      addr_q <= addr_d;
      bcnt_q <= bcnt_d;
    end
  end

  assign addr = addr_q;
  assign last = beat & ~cfg.cont & (bcnt_q == mask[BW-1:0]);

  // R4: linear stepping adds exactly one
  p_linear_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(step && !wrap_on) |-> (addr_q == $past(addr_q) + AW'(1)));

  // R3: wrapping never disturbs bits above the length boundary
  p_wrap_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(step && wrap_on) |-> (((addr_q ^ $past(addr_q)) & ~$past(mask)) == '0));

  // R2: beat index stays inside a fixed-length burst
  p_len_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !cfg.cont) |-> (bcnt_q <= mask[BW-1:0]));

endmodule

// File: rtl/psram_burst_seq.sv
module psram_burst_seq
  import psb_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          adv_n,
  input  logic          we_n,
  input  logic          cfg_wr,
  input  logic          busy_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] word_addr_o,
  output logic          beat_o,
  output logic          beat_we_o,
  output logic          wait_o,
  output logic          wait_oe_o
);

  localparam int CW = 4;

  cfg_t cfg;
  logic sel, start, cfg_load, step, last, wait_act, beat;

  assign sel      = ~ce_n;
  assign cfg_load = sel & cfg_wr;
  assign start    = sel & ~adv_n & ~cfg_wr;

  psb_cfg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cfg_load),
    .wdata (addr_i[15:0]),
    .cfg   (cfg)
  );

  psb_ctrl #(.CW(CW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (sel),
    .start    (start),
    .busy_i   (busy_i),
    .we_i     (~we_n),
    .last     (last),
    .cfg      (cfg),
    .beat     (beat),
    .beat_we  (beat_we_o),
    .step     (step),
    .wait_act (wait_act)
  );

  psb_addr #(.AW(AW)) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (start),
    .step       (step),
    .beat       (beat),
    .start_addr (addr_i),
    .cfg        (cfg),
    .addr       (word_addr_o),
    .last       (last)
  );

  assign beat_o    = beat;
  assign wait_o    = cfg.act_high ? wait_act : ~wait_act;
  assign wait_oe_o = sel;

endmodule

// File: tb/tb_psram_burst_seq.sv
module tb_psram_burst_seq;

  localparam int AW = 20;

  logic          clk, rst_n, ce_n, adv_n, we_n, cfg_wr, busy_i;
  logic [AW-1:0] addr_i, word_addr_o;
  logic          beat_o, beat_we_o, wait_o, wait_oe_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  psram_burst_seq #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .adv_n(adv_n), .we_n(we_n),
    .cfg_wr(cfg_wr), .busy_i(busy_i), .addr_i(addr_i),
    .word_addr_o(word_addr_o), .beat_o(beat_o), .beat_we_o(beat_we_o),
    .wait_o(wait_o), .wait_oe_o(wait_oe_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h at %0t", req, what, got, exp, $time);
    end
  endtask

  function automatic logic [15:0] mk(input logic [2:0] bl, input bit lin,
                                     input logic [2:0] lat, input bit fix,
                                     input bit pol, input bit lead);
    return {1'b0, fix, lat, pol, 1'b0, lead, 4'b0000, lin, bl};
  endfunction

  // R11: configuration write with ADV# low must not start a burst
  task automatic wr_cfg(input logic [15:0] val, input bit pol);
    @(negedge clk);
    ce_n = 0; adv_n = 0; cfg_wr = 1; addr_i = {4'h0, val};
    @(negedge clk);
    check("R11", "beat after cfg write", beat_o, 0);
    check("R11", "wait idle level", wait_o, pol ? 1'b0 : 1'b1);
    ce_n = 1; adv_n = 1; cfg_wr = 0; addr_i = '0;
  endtask

  task automatic run_burst(input string req, input logic [AW-1:0] st,
                           input bit busy, input bit we, input int lat,
                           input int nb, input bit wrp, input int lg,
                           input bit pol, input bit lead, input int obs);
    logic [AW-1:0] mask, ea;
    bit eb, wl;
    mask = (AW'(1) << lg) - AW'(1);
    @(negedge clk);
    ce_n = 0; adv_n = 0; addr_i = st; busy_i = busy; we_n = ~we;
    @(negedge clk);
    adv_n = 1; busy_i = 0; addr_i = '0;
    for (int k = 0; k <= lat + obs; k++) begin
      if (k > 0) @(negedge clk);
      eb = (k >= lat) && (nb == 0 || (k - lat) < nb);
      wl = lead ? (k < lat - 1) : (k < lat);
      ea = wrp ? ((st & ~mask) | ((st + AW'(k - lat)) & mask)) : st + AW'(k - lat);
      check(req, "beat", beat_o, eb);
      check("R12", "write beat flag", beat_we_o, eb & we);
      check(req, "wait pin", wait_o, pol ? wl : !wl);
      if (eb) check(req, "word address", word_addr_o, ea);
    end
    ce_n = 1; we_n = 1;
    #1 check("R10", "wait enable off", wait_oe_o, 0);
    @(negedge clk);
    check("R10", "beat after deselect", beat_o, 0);
  endtask

  task automatic t_reset;
    check("R1", "beat at reset", beat_o, 0);
    check("R10", "wait enable with CE high", wait_oe_o, 0);
    // R1 + R4: default continuous linear burst crossing a 32-word boundary
    run_burst("R1", 20'h00FFC, 0, 0, 3, 0, 0, 5, 1, 1, 40);
  endtask

  task automatic t_variable;
    run_burst("R6", 20'h00100, 1, 0, 6, 0, 0, 5, 1, 1, 4);
    run_burst("R6", 20'h00200, 0, 0, 3, 0, 0, 5, 1, 1, 4);
  endtask

  task automatic t_len4_wrap_fixed;
    wr_cfg(mk(3'b001, 0, 3'd2, 1, 1, 1), 1);
    run_burst("R3", 20'h00006, 1, 0, 2, 4, 1, 2, 1, 1, 6);
  endtask

  task automatic t_len8_linear;
    wr_cfg(mk(3'b010, 1, 3'd4, 1, 1, 1), 1);
    run_burst("R4", 20'h0003D, 0, 0, 4, 8, 0, 3, 1, 1, 10);
  endtask

  task automatic t_len32_wrap;
    wr_cfg(mk(3'b100, 0, 3'd6, 0, 1, 1), 1);
    run_burst("R2", 20'h0005E, 0, 0, 6, 32, 1, 5, 1, 1, 34);
  endtask

  task automatic t_len16_pol_low;
    wr_cfg(mk(3'b011, 0, 3'd5, 0, 0, 0), 0);
    run_burst("R8", 20'h001F3, 1, 0, 10, 16, 1, 4, 0, 0, 18);
    wr_cfg(mk(3'b011, 0, 3'd5, 1, 0, 1), 0);
    run_burst("R9", 20'h00400, 1, 0, 5, 16, 1, 4, 0, 1, 18);
  endtask

  task automatic t_reserved;
    wr_cfg(mk(3'b101, 1, 3'd7, 0, 1, 1), 1);
    run_burst("R7", 20'h0FFFE, 0, 0, 3, 0, 0, 5, 1, 1, 36);
    wr_cfg(mk(3'b000, 0, 3'd1, 1, 1, 1), 1);
    run_burst("R7", 20'h0001E, 0, 0, 3, 0, 0, 5, 1, 1, 6);
  endtask

  task automatic t_write_and_abort;
    wr_cfg(mk(3'b111, 1, 3'd2, 1, 1, 1), 1);
    run_burst("R12", 20'h00020, 0, 1, 2, 0, 0, 5, 1, 1, 3);
    // R10: deselect after two beats cuts the burst short
    run_burst("R10", 20'h00030, 0, 0, 2, 0, 0, 5, 1, 1, 1);
  endtask

  initial begin
    rst_n = 0; ce_n = 1; adv_n = 1; we_n = 1; cfg_wr = 0; busy_i = 0; addr_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_variable();
    t_len4_wrap_fixed();
    t_len8_linear();
    t_len32_wrap();
    t_len16_pol_low();
    t_reserved();
    t_write_and_abort();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule